// File: doc/BRIEF.md
# Stream Packet Insertion Buffer

This block keeps one packet written by a host and splices it into an outgoing stream of fixed-size packets made of 32-bit quadlets. The stream is divided into slots, each marked by a one-cycle `slot_tick`. A slot that starts without a live packet from upstream is a gap. When insertion is armed, the stored packet fills the first such gap. Live traffic always goes through untouched, with one cycle of latency.

The host loads the buffer through a data port whose write and read pointers advance on their own after each access. The host also has pointer clears, an autofill command, a size field, a 3-bit target-stream tag and a 16-bit per-slot time offset. Buffer access and pointer control only work while insertion is disabled. The block keeps a running slot timestamp in cycle-timer form: 4 upper bits, plus 12 lower bits that count modulo 3072. Each inserted packet is stamped from that running value. One enable produces exactly one insertion. The host re-arms the block by disabling insertion and enabling it again.

Top module: `pkt_splice_top`

## Requirements
- R1: After reset `out_valid`, `out_ins`, `ins_done`, `wr_ptr` and `rd_ptr` are all 0.
- R2: While `cfg_en`=0, a `host_wr` cycle stores `host_wdata` at `wr_ptr` and advances it. A `host_rd` cycle loads the word at `rd_ptr` into `host_rdata` on the next edge and advances `rd_ptr`.
- R3: A pointer whose incremented value equals `cfg_size` wraps to 0. A `cfg_size` of 0 means 64 quadlets, so the pointer wraps after location 63.
- R4: While disabled, `wptr_clr` sets `wr_ptr` to 0 and `rptr_clr` sets `rd_ptr` to 0.
- R5: While `cfg_en`=1, host writes, host reads, pointer clears and `fill_go` have no effect on buffer contents, pointers or `host_rdata`.
- R6: While disabled, `fill_go` writes 0x0000FFFF into every location from `wr_ptr` through 63 and leaves `wr_ptr` unchanged. `fill_go` takes priority over a `host_wr` in the same cycle.
- R7: A live quadlet (`in_valid`=1) appears on the outputs one cycle later with its `in_sop`/`in_eop`, with `out_ins`=0 and `out_tag`=0. On a start quadlet `out_stamp` carries `in_stamp`, otherwise it is 0.
- R8: An insertion starts on a `slot_tick` cycle when all of the following hold: `in_valid`=0, `cfg_en`=1, no live packet is open and `ins_done`=0. From the next edge it emits buffer words 0..len-1 on consecutive cycles with `out_ins`=1 and `out_tag`=`cfg_tag`. `out_sop` is set on the first word and `out_eop` on the last.
- R9: No insertion starts while a live packet is open (start seen, end not yet seen) or while `cfg_en`=0.
- R10: On each `slot_tick`, the running timestamp loads `in_stamp` if a live start is present; otherwise it becomes the previous value plus `cfg_offset`. The low 12 bits add modulo 3072 and carry into the upper 4 bits, which wrap modulo 16. An inserted packet's first word carries the new value on `out_stamp`.
- R11: `ins_done` rises on the edge after the last inserted word is emitted and blocks further insertions. It clears only when `cfg_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 32 | Host read data, registered |
| wptr_clr | input | 1 | Clear write pointer |
| rptr_clr | input | 1 | Clear read pointer |
| fill_go | input | 1 | Autofill from write pointer to end |
| cfg_en | input | 1 | Insertion enable |
| cfg_size | input | 6 | Packet length in quadlets (0 = 64) |
| cfg_tag | input | 3 | Target stream tag for inserted packets |
| cfg_offset | input | 16 | Per-slot time offset, cycle-timer form |
| wr_ptr | output | 6 | Current write pointer |
| rd_ptr | output | 6 | Current read pointer |
| slot_tick | input | 1 | Start of a packet slot |
| in_valid | input | 1 | Live quadlet valid |
| in_sop | input | 1 | Live start of packet |
| in_eop | input | 1 | Live end of packet |
| in_data | input | 32 | Live quadlet |
| in_stamp | input | 16 | Live packet timestamp (with start) |
| out_valid | output | 1 | Output quadlet valid |
| out_sop | output | 1 | Output start of packet |
| out_eop | output | 1 | Output end of packet |
| out_data | output | 32 | Output quadlet |
| out_ins | output | 1 | Output quadlet comes from the buffer |
| out_tag | output | 3 | Target tag of inserted quadlet |
| out_stamp | output | 16 | Timestamp on start quadlets |
| ins_done | output | 1 | Insertion has completed since enable |

## Verification
The splice is tried with four slot patterns:
- An empty slot while armed, which must be filled.
- A slot with a live start, which must pass through untouched.
- A `slot_tick` in the middle of an open live packet that has a gap in its valids, which must not be filled.
- An empty slot after completion or while disabled, which must stay empty.

Together these separate "slot is empty" from "no valid this cycle" and from "armed". A table of base stamp and offset pairs sets the running timestamp through a live start and reads it back from the following insertion. The pairs cover a low-field wrap at 3072, a wrap of the upper field and plain sums, which separates a binary carry from the modulo-3072 carry. Host-side tests compare pointer wrap at a small size and at size 0, and check autofill against words written just below the write pointer.

// File: rtl/pkt_splice_pkg.sv
package pkt_splice_pkg;
  localparam int unsigned QW      = 32;
  localparam int unsigned PW      = 6;
  localparam int unsigned DEPTH   = 1 << PW;
  localparam int unsigned TW      = 16;
  localparam int unsigned LOW_W   = 12;
  localparam int unsigned LOW_MOD = 3072;
  localparam logic [QW-1:0] FILL_WORD = 32'h0000_FFFF;

  // next pointer value, wrapping when it reaches the configured size
  function automatic logic [PW-1:0] ptr_step(input logic [PW-1:0] p, input logic [PW-1:0] size);
    logic [PW-1:0] n;
    n = p + 1'b1;
    return (n == size) ? '0 : n;
  endfunction

  // packet length in quadlets; size 0 stands for a full buffer
  function automatic logic [PW:0] pkt_len(input logic [PW-1:0] size);
    return (size == '0) ? (PW+1)'(DEPTH) : {1'b0, size};
  endfunction

  // cycle-timer style addition: low field modulo 3072 with carry upward
  function automatic logic [TW-1:0] ts_add(input logic [TW-1:0] a, input logic [TW-1:0] b);
    logic [LOW_W:0]      lo;
    logic                cy;
    logic [TW-LOW_W-1:0] hi;
    lo = {1'b0, a[LOW_W-1:0]} + {1'b0, b[LOW_W-1:0]};
    cy = (lo >= (LOW_W+1)'(LOW_MOD));
    if (cy) lo = lo - (LOW_W+1)'(LOW_MOD);
    hi = a[TW-1:LOW_W] + b[TW-1:LOW_W] + {{(TW-LOW_W-1){1'b0}}, cy};
    return {hi, lo[LOW_W-1:0]};
  endfunction
endpackage

// File: rtl/pkt_splice_store.sv
module pkt_splice_store
  import pkt_splice_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock,
  input  logic          host_wr,
  input  logic [QW-1:0] host_wdata,
  input  logic          host_rd,
  input  logic          wptr_clr,
  input  logic          rptr_clr,
  input  logic          fill_go,
  input  logic [PW-1:0] cfg_size,
  input  logic [PW-1:0] str_idx,
  output logic [QW-1:0] str_data,
  output logic [QW-1:0] host_rdata,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr
);
  logic [QW-1:0] mem [DEPTH];

  // named events for assertions
  logic do_fill, do_wr, do_rd;
  assign do_fill = !lock && fill_go;
  assign do_wr   = !lock && host_wr && !fill_go;
  assign do_rd   = !lock && host_rd;

  assign str_data = mem[str_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (do_fill) begin
      for (int i = 0; i < DEPTH; i++)
        if (PW'(i) >= wr_ptr) mem[i] <= FILL_WORD;
    end else if (do_wr) begin
      mem[wr_ptr] <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      host_rdata <= '0;
    end else begin
      if (!lock && wptr_clr)  wr_ptr <= '0;
      else if (do_wr)         wr_ptr <= ptr_step(wr_ptr, cfg_size);
      if (!lock && rptr_clr)  rd_ptr <= '0;
      else if (do_rd)         rd_ptr <= ptr_step(rd_ptr, cfg_size);
      if (do_rd)              host_rdata <= mem[rd_ptr];
    end
  end

  p_lock_wptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock) |-> $stable(wr_ptr) && $stable(rd_ptr) && $stable(host_rdata));
  p_fill_keeps_wptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(do_fill) && !$past(wptr_clr) |-> $stable(wr_ptr));
endmodule

// File: rtl/pkt_splice_arb.sv
module pkt_splice_arb
  import pkt_splice_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_tick,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic          cfg_en,
  input  logic [PW-1:0] cfg_size,
  output logic          ins_go,
  output logic          ins_emit,
  output logic          ins_last,
  output logic [PW-1:0] cur_idx,
  output logic          ins_done
);
  logic          live_busy;
  logic          ins_busy;
  logic [PW-1:0] ins_idx;
  logic [PW:0]   len;

  assign len      = pkt_len(cfg_size);
  assign ins_go   = slot_tick && !in_valid && !live_busy && cfg_en && !ins_done && !ins_busy;
  assign ins_emit = ins_go || ins_busy;
  assign cur_idx  = ins_go ? '0 : ins_idx;
  assign ins_last = ins_emit && ({1'b0, cur_idx} == len - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_busy <= 1'b0;
      ins_busy  <= 1'b0;
      ins_idx   <= '0;
      ins_done  <= 1'b0;
    end else begin
      if (in_valid && in_eop)      live_busy <= 1'b0;
      else if (in_valid && in_sop) live_busy <= 1'b1;
      if (ins_emit) begin
        ins_busy <= !ins_last;
        ins_idx  <= cur_idx + 1'b1;
      end
      if (!cfg_en)       ins_done <= 1'b0;
      else if (ins_last) ins_done <= 1'b1;
    end
  end

  p_done_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ins_done) |-> $past(ins_last));
  p_no_go_in_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    live_busy |-> !ins_go);
endmodule

// File: rtl/pkt_splice_stamp.sv
module pkt_splice_stamp
  import pkt_splice_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_tick,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic [TW-1:0] in_stamp,
  input  logic [TW-1:0] cfg_offset,
  output logic [TW-1:0] ts_next
);
  logic [TW-1:0] ts;

  assign ts_next = ts_add(ts, cfg_offset);

  always_ff @(posedge clk) begin
    if (!rst_n)                                ts <= '0;
    else if (slot_tick && in_valid && in_sop)  ts <= in_stamp;
    else if (slot_tick)                        ts <= ts_next;
  end

  p_low_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(slot_tick) && !$past(in_valid) && ($past(cfg_offset[LOW_W-1:0]) < 12'(LOW_MOD))
      && ($past(ts[LOW_W-1:0]) < 12'(LOW_MOD)) |-> ts[LOW_W-1:0] < 12'(LOW_MOD));
endmodule

// File: rtl/pkt_splice_top.sv
module pkt_splice_top
  import pkt_splice_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [31:0] host_wdata,
  input  logic        host_rd,
  output logic [31:0] host_rdata,
  input  logic        wptr_clr,
  input  logic        rptr_clr,
  input  logic        fill_go,
  input  logic        cfg_en,
  input  logic [5:0]  cfg_size,
  input  logic [2:0]  cfg_tag,
  input  logic [15:0] cfg_offset,
  output logic [5:0]  wr_ptr,
  output logic [5:0]  rd_ptr,
  input  logic        slot_tick,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic [31:0] in_data,
  input  logic [15:0] in_stamp,
  output logic        out_valid,
  output logic        out_sop,
  output logic        out_eop,
  output logic [31:0] out_data,
  output logic        out_ins,
  output logic [2:0]  out_tag,
  output logic [15:0] out_stamp,
  output logic        ins_done
);
  logic          ins_go, ins_emit, ins_last;
  logic [PW-1:0] cur_idx;
  logic [QW-1:0] str_data;
  logic [TW-1:0] ts_next;

  pkt_splice_store u_store (
    .clk, .rst_n, .lock(cfg_en), .host_wr, .host_wdata, .host_rd,
    .wptr_clr, .rptr_clr, .fill_go, .cfg_size, .str_idx(cur_idx),
    .str_data, .host_rdata, .wr_ptr, .rd_ptr
  );

  pkt_splice_arb u_arb (
    .clk, .rst_n, .slot_tick, .in_valid, .in_sop, .in_eop, .cfg_en, .cfg_size,
    .ins_go, .ins_emit, .ins_last, .cur_idx, .ins_done
  );

  pkt_splice_stamp u_stamp (
    .clk, .rst_n, .slot_tick, .in_valid, .in_sop, .in_stamp, .cfg_offset, .ts_next
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_sop <= 1'b0; out_eop <= 1'b0; out_data <= '0;
      out_ins <= 1'b0; out_tag <= '0; out_stamp <= '0;
    end else if (in_valid) begin
      out_valid <= 1'b1; out_sop <= in_sop; out_eop <= in_eop; out_data <= in_data;
      out_ins <= 1'b0; out_tag <= '0; out_stamp <= in_sop ? in_stamp : '0;
    end else if (ins_emit) begin
      out_valid <= 1'b1; out_sop <= ins_go; out_eop <= ins_last; out_data <= str_data;
      out_ins <= 1'b1; out_tag <= cfg_tag; out_stamp <= ins_go ? ts_next : '0;
    end else begin
      out_valid <= 1'b0; out_sop <= 1'b0; out_eop <= 1'b0; out_data <= '0;
      out_ins <= 1'b0; out_tag <= '0; out_stamp <= '0;
    end
  end

  p_live_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid && !out_ins);
  p_ins_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop && out_ins |-> $past(cfg_en));
endmodule

// File: tb/pkt_splice_top_tb.sv
module pkt_splice_top_tb;
  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0, wptr_clr = 0, rptr_clr = 0, fill_go = 0, cfg_en = 0;
  logic [31:0] host_wdata = 0, host_rdata, in_data = 0, out_data;
  logic [5:0]  cfg_size = 0, wr_ptr, rd_ptr;
  logic [2:0]  cfg_tag = 0, out_tag;
  logic [15:0] cfg_offset = 0, in_stamp = 0, out_stamp;
  logic slot_tick = 0, in_valid = 0, in_sop = 0, in_eop = 0;
  logic out_valid, out_sop, out_eop, out_ins, ins_done;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pkt_splice_top u_dut (.*);

  // base stamp, offset, expected inserted stamp
  localparam logic [47:0] VEC [5] = '{
    {16'h0BFF, 16'h0001, 16'h1000},
    {16'hFBFF, 16'h0001, 16'h0000},
    {16'h0A00, 16'h0300, 16'h1100},
    {16'h2100, 16'h1050, 16'h3150},
    {16'h0000, 16'h0000, 16'h0000}
  };

  function automatic logic [15:0] ref_sum(input logic [15:0] a, input logic [15:0] b);
    int unsigned t;
    t = (a[15:12] * 3072 + a[11:0] + b[15:12] * 3072 + b[11:0]) % (16 * 3072);
    return {4'(t / 3072), 12'(t % 3072)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic hwrite(input logic [31:0] d);
    host_wr = 1; host_wdata = d; tick; host_wr = 0;
  endtask

  task automatic hread;
    host_rd = 1; tick; host_rd = 0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick;
    // R1 reset state
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 wr_ptr", 32'(wr_ptr), 0);
    chk("R1 ins_done", 32'(ins_done), 0);
    rst_n = 1; tick;
    chk("R1 rd_ptr", 32'(rd_ptr), 0);

    // R2, R3 writes with size 4
    cfg_size = 4; cfg_tag = 5; cfg_offset = 16'h1234;
    hwrite(32'hA0); hwrite(32'hA1);
    chk("R2 wr_ptr advance", 32'(wr_ptr), 2);
    hwrite(32'hA2); hwrite(32'hA3);
    chk("R3 wr_ptr wrap at size", 32'(wr_ptr), 0);
    hread;
    chk("R2 host_rdata", host_rdata, 32'hA0);
    chk("R2 rd_ptr advance", 32'(rd_ptr), 1);
    hread; hread; hread;
    chk("R2 last read", host_rdata, 32'hA3);
    chk("R3 rd_ptr wrap at size", 32'(rd_ptr), 0);

    // R4 pointer clears
    hwrite(32'hA0); hread;
    wptr_clr = 1; rptr_clr = 1; tick; wptr_clr = 0; rptr_clr = 0;
    chk("R4 wptr_clr", 32'(wr_ptr), 0);
    chk("R4 rptr_clr", 32'(rd_ptr), 0);

    // R5 lockout while enabled
    hwrite(32'hA0); hread;
    cfg_en = 1; tick;
    host_wr = 1; host_wdata = 32'hDEAD; host_rd = 1; wptr_clr = 1; rptr_clr = 1; fill_go = 1;
    tick;
    host_wr = 0; host_rd = 0; wptr_clr = 0; rptr_clr = 0; fill_go = 0;
    chk("R5 wr_ptr locked", 32'(wr_ptr), 1);
    chk("R5 rd_ptr locked", 32'(rd_ptr), 1);
    chk("R5 rdata locked", host_rdata, 32'hA0);

    // R8, R10 insertion into empty slot
    slot_tick = 1; tick; slot_tick = 0;
    chk("R8 sop word0", {out_valid, out_sop, out_ins, out_eop}, 4'b1110);
    chk("R5 R8 data0 untouched", out_data, 32'hA0);
    chk("R8 tag", 32'(out_tag), 5);
    chk("R10 first stamp", 32'(out_stamp), 32'(ref_sum(16'h0000, 16'h1234)));
    tick; chk("R8 data1", out_data, 32'hA1);
    tick; chk("R8 data2", out_data, 32'hA2);
    chk("R8 mid no eop", 32'(out_eop), 0);
    tick; chk("R8 data3", out_data, 32'hA3);
    chk("R8 eop last", {out_valid, out_ins, out_eop}, 3'b111);
    chk("R11 done set", 32'(ins_done), 1);
    tick; chk("R8 ends", 32'(out_valid), 0);
    slot_tick = 1; tick; slot_tick = 0;
    chk("R11 no second insertion", 32'(out_valid), 0);

    // R11 re-arm
    cfg_en = 0; tick;
    chk("R11 done cleared", 32'(ins_done), 0);
    cfg_en = 1;

    // R7 live pass-through, R9 mid-packet tick
    slot_tick = 1; in_valid = 1; in_sop = 1; in_data = 32'h11; in_stamp = 16'h0777; tick;
    slot_tick = 0; in_valid = 0; in_sop = 0;
    chk("R7 live sop", {out_valid, out_sop, out_ins}, 3'b110);
    chk("R7 live data", out_data, 32'h11);
    chk("R7 live stamp", 32'(out_stamp), 32'h0777);
    chk("R7 live tag", 32'(out_tag), 0);
    slot_tick = 1; tick; slot_tick = 0;
    chk("R9 no insert in open live", 32'(out_valid), 0);
    in_valid = 1; in_eop = 1; in_data = 32'h12; tick; in_valid = 0; in_eop = 0;
    chk("R7 live eop", {out_valid, out_eop, out_ins}, 3'b110);
    chk("R7 live data2", out_data, 32'h12);
    cfg_en = 0; tick;
    slot_tick = 1; tick; slot_tick = 0;
    chk("R9 no insert when disabled", 32'(out_valid), 0);

    // R6 autofill, R3 size 0
    wptr_clr = 1; rptr_clr = 1; tick; wptr_clr = 0; rptr_clr = 0;
    cfg_size = 0;
    hwrite(32'hC0); hwrite(32'hC1);
    fill_go = 1; host_wr = 1; host_wdata = 32'hBAD; tick; fill_go = 0; host_wr = 0;
    chk("R6 wr_ptr kept", 32'(wr_ptr), 2);
    for (int i = 0; i < 64; i++) begin
      hread;
      if (i == 0)      chk("R6 below fill 0", host_rdata, 32'hC0);
      else if (i == 1) chk("R6 below fill 1", host_rdata, 32'hC1);
      else             chk("R6 filled", host_rdata, 32'h0000FFFF);
    end
    chk("R3 size0 wraps after 63", 32'(rd_ptr), 0);

    // R10 table of stamp vectors
    cfg_size = 1;
    for (int v = 0; v < 5; v++) begin
      cfg_en = 0; cfg_offset = VEC[v][31:16]; tick;
      cfg_en = 1;
      slot_tick = 1; in_valid = 1; in_sop = 1; in_eop = 1; in_stamp = VEC[v][47:32]; tick;
      slot_tick = 0; in_valid = 0; in_sop = 0; in_eop = 0;
      slot_tick = 1; tick; slot_tick = 0;
      chk("R10 vector insert", {out_valid, out_ins, out_sop, out_eop}, 4'b1111);
      chk("R10 vector stamp", 32'(out_stamp), 32'(VEC[v][15:0]));
      chk("R10 model agrees", 32'(ref_sum(VEC[v][47:32], VEC[v][31:16])), 32'(VEC[v][15:0]));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule